// File: doc/BRIEF.md
# Receive Idle Condition Detector

This block watches the serial receive line once a character has finished. It raises a sticky idle flag after the line has stayed high for a programmed number of whole character frames. Frame time is measured in ticks of a 16x oversampling strobe. The length of one frame is worked out inside the block from the word-size, parity and stop-bit settings, so the threshold tracks the line format.

Counting is armed by the receiver's character-complete pulse. The count is restarted by a low level on the line, by the receiver reporting that it is busy, or by another character. The flag fires once per arming and stays set until software writes a one to clear it. Two separate enables route the flag to an interrupt request and to a receive DMA request. A level output tells whether a reception is in progress.

Top module: `rx_idle_detect`

## Requirements
- R1: One frame lasts 16 x (1 + D + P + S) tick strobes. D is 8 when `word8` is 1 and 7 otherwise. P is 1 when `parity_en` is 1 and 0 otherwise. S is 2 when `two_stop` is 1 and 1 otherwise. This gives 144 to 192 ticks.
- R2: `idle_sel` codes 0, 1, 2 and 3 select thresholds of more than 4, 8, 16 and 32 frames. With N the selected value, `idle_flag` rises on the clock edge that consumes tick number (N+1) x frame length, counted from the first edge after the arming event.
- R3: No idle flag is raised unless a `char_done` pulse has occurred since reset or since the previous firing.
- R4: A sampled low `rx_line`, a high `rx_busy`, or a `char_done` pulse restarts the count from zero. The count advances only on clock edges where `baud_tick16` is 1.
- R5: `idle_flag` stays set until `idle_clr` is sampled high, and it reads 0 after that edge. If firing and clearing fall on the same edge, the flag stays set.
- R6: After firing, the block does not set the flag again until another `char_done` pulse arrives, however long the line stays idle.
- R7: `idle_irq` equals `idle_flag` AND `idle_irq_en`.
- R8: `idle_dma_req` equals `idle_flag` AND `idle_dma_en`.
- R9: `rx_idle` is 1 when `rx_busy` is 0 and is 0 while a reception is in progress.
- R10: After reset, `idle_flag`, `idle_irq` and `idle_dma_req` are 0 and the block is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick16 | input | 1 | 16x oversampling strobe, one cycle wide |
| rx_line | input | 1 | Synchronised receive line, idle high |
| char_done | input | 1 | Pulse when the receiver completes a character |
| rx_busy | input | 1 | Receiver is inside a character |
| word8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| parity_en | input | 1 | Parity bit present in frame |
| two_stop | input | 1 | 1: two stop bits, 0: one |
| idle_sel | input | 2 | Threshold code (4/8/16/32 frames) |
| idle_irq_en | input | 1 | Route flag to interrupt |
| idle_dma_en | input | 1 | Route flag to receive DMA request |
| idle_clr | input | 1 | Write-one-to-clear strobe for the flag |
| idle_flag | output | 1 | Sticky idle condition flag |
| rx_idle | output | 1 | Receiver idle level |
| idle_irq | output | 1 | Interrupt request |
| idle_dma_req | output | 1 | Receive DMA request |

## Verification
A wrong tick or frame counter shows up as a flag edge one or more cycles away from (N+1) x frame length after the anchor edge. Each threshold and frame format is therefore checked on the exact edge, and on the edge just before it. A stuck arming bit shows either as a flag with no character or as a second firing after a clear; both are observed over windows longer than the largest threshold. Gating faults on the request outputs are visible in the same cycle the enable or the flag changes.

// File: rtl/rx_idle_pkg.sv
package rx_idle_pkg;

  // Number of bit periods in one character frame.
  function automatic int unsigned frame_bits(logic word8, logic par_en, logic stop2);
    int unsigned n;
    n = 1;
    n = n + (word8 ? 8 : 7);
    n = n + (par_en ? 1 : 0);
    n = n + (stop2 ? 2 : 1);
    return n;
  endfunction

  // Idle threshold in frames for a given select code.
  function automatic int unsigned idle_frames(logic [1:0] sel, int unsigned base);
    return base << sel;
  endfunction

endpackage

// File: rtl/idle_frame_len.sv
module idle_frame_len #(
  parameter int TICKS_PER_BIT = 16,
  parameter int TICK_W        = 8
) (
  input  logic              word8,
  input  logic              parity_en,
  input  logic              two_stop,
  output logic [TICK_W-1:0] frame_ticks
);
  import rx_idle_pkg::*;

  always_comb begin
    frame_ticks = TICK_W'(frame_bits(word8, parity_en, two_stop) * TICKS_PER_BIT);
  end
endmodule

// File: rtl/idle_frame_timer.sv
module idle_frame_timer #(
  parameter int TICK_W  = 8,
  parameter int FRAME_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               line,
  input  logic               char_done,
  input  logic               rx_busy,
  input  logic [TICK_W-1:0]  frame_ticks,
  input  logic [FRAME_W-1:0] thr_frames,
  output logic               fire
);
  localparam logic [FRAME_W-1:0] FRAME_MAX = '1;

  logic               armed;
  logic [TICK_W-1:0]  tick_cnt;
  logic [FRAME_W-1:0] frame_cnt;
  logic               hold;
  logic               frame_end;

  // Any of these restarts the idle window.
  assign hold      = !armed || rx_busy || !line || char_done;
  // >= keeps the counter safe if the format shrinks mid-window.
  assign frame_end = tick && (tick_cnt >= TICK_W'(frame_ticks - 1'b1));
  assign fire      = !hold && frame_end && (frame_cnt == thr_frames);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      tick_cnt  <= '0;
      frame_cnt <= '0;
    end else begin
      if (char_done)  armed <= 1'b1;
      else if (fire)  armed <= 1'b0;

      if (hold) begin
        tick_cnt  <= '0;
        frame_cnt <= '0;
      end else if (tick) begin
        if (frame_end) begin
          tick_cnt <= '0;
          if (frame_cnt != FRAME_MAX) frame_cnt <= frame_cnt + 1'b1;
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end
    end
  end

  // R3: arming only ever follows a character completion
  a_r3_arm_after_char: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(char_done));

  // R6: a firing disarms the window
  a_r6_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed);

  // R4: busy receiver leaves the window empty
  a_r4_busy_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |=> (tick_cnt == '0 && frame_cnt == '0));

  // R4: without a tick the counters do not move
  a_r4_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hold) |=> $stable(tick_cnt) && $stable(frame_cnt));
endmodule

// File: rtl/idle_flag_reg.sv
module idle_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (fire)  flag <= 1'b1;
    else if (clr)   flag <= 1'b0;
  end

  // R5: sticky without a clear
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag);

  // R5: a clear without a new firing empties the flag
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !fire |=> !flag);

  // R2: a firing is visible on the next cycle
  a_r2_fire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flag);
endmodule

// File: rtl/rx_idle_detect.sv
module rx_idle_detect #(
  parameter int TICKS_PER_BIT = 16,
  parameter int BASE_FRAMES   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick16,
  input  logic       rx_line,
  input  logic       char_done,
  input  logic       rx_busy,
  input  logic       word8,
  input  logic       parity_en,
  input  logic       two_stop,
  input  logic [1:0] idle_sel,
  input  logic       idle_irq_en,
  input  logic       idle_dma_en,
  input  logic       idle_clr,
  output logic       idle_flag,
  output logic       rx_idle,
  output logic       idle_irq,
  output logic       idle_dma_req
);
  import rx_idle_pkg::*;

  localparam int MAX_FRAMES = BASE_FRAMES << 3;
  localparam int FRAME_W    = $clog2(MAX_FRAMES + 2);
  localparam int TICK_W     = $clog2(TICKS_PER_BIT * 12 + 1);

  logic [TICK_W-1:0]  frame_ticks;
  logic [FRAME_W-1:0] thr_frames;
  logic               fire;

  assign thr_frames = FRAME_W'(idle_frames(idle_sel, BASE_FRAMES));

  idle_frame_len #(.TICKS_PER_BIT(TICKS_PER_BIT), .TICK_W(TICK_W)) u_len (
    .word8       (word8),
    .parity_en   (parity_en),
    .two_stop    (two_stop),
    .frame_ticks (frame_ticks)
  );

  idle_frame_timer #(.TICK_W(TICK_W), .FRAME_W(FRAME_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (baud_tick16),
    .line        (rx_line),
    .char_done   (char_done),
    .rx_busy     (rx_busy),
    .frame_ticks (frame_ticks),
    .thr_frames  (thr_frames),
    .fire        (fire)
  );

  idle_flag_reg u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .clr   (idle_clr),
    .flag  (idle_flag)
  );

  assign rx_idle      = !rx_busy;
  assign idle_irq     = idle_flag && idle_irq_en;
  assign idle_dma_req = idle_flag && idle_dma_en;

  // R1: computed frame length stays inside the legal format range
  a_r1_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ticks >= TICK_W'(9 * TICKS_PER_BIT)) && (frame_ticks <= TICK_W'(12 * TICKS_PER_BIT)));

  // R7: interrupt never asserted without the flag
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    idle_irq |-> idle_flag);

  // R8: DMA request never asserted without the flag
  a_r8_dma_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    idle_dma_req |-> idle_flag);
endmodule

// File: tb/sim_rx_idle_detect.sv
`timescale 1ns/1ps
module sim_rx_idle_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick16 = 1'b1;
  logic       rx_line = 1'b1;
  logic       char_done = 1'b0;
  logic       rx_busy = 1'b0;
  logic       word8 = 1'b1;
  logic       parity_en = 1'b0;
  logic       two_stop = 1'b0;
  logic [1:0] idle_sel = 2'd0;
  logic       idle_irq_en = 1'b0;
  logic       idle_dma_en = 1'b0;
  logic       idle_clr = 1'b0;
  logic       idle_flag, rx_idle, idle_irq, idle_dma_req;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rx_idle_detect u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick16(baud_tick16), .rx_line(rx_line),
    .char_done(char_done), .rx_busy(rx_busy), .word8(word8), .parity_en(parity_en),
    .two_stop(two_stop), .idle_sel(idle_sel), .idle_irq_en(idle_irq_en),
    .idle_dma_en(idle_dma_en), .idle_clr(idle_clr), .idle_flag(idle_flag),
    .rx_idle(rx_idle), .idle_irq(idle_irq), .idle_dma_req(idle_dma_req)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Bench-side model of the frame length and threshold.
  function automatic int exp_ticks(logic w8, logic p, logic s2, logic [1:0] sel);
    int bits;
    bits = 1 + (w8 ? 8 : 7) + (p ? 1 : 0) + (s2 ? 2 : 1);
    return ((4 * (1 << sel)) + 1) * 16 * bits;
  endfunction

  task automatic set_fmt(logic w8, logic p, logic s2, logic [1:0] sel);
    @(negedge clk);
    word8 = w8; parity_en = p; two_stop = s2; idle_sel = sel;
  endtask

  // Leaves the bench at the falling edge after the arming edge.
  task automatic send_char();
    @(negedge clk) char_done = 1'b1;
    @(negedge clk) char_done = 1'b0;
  endtask

  task automatic expect_fire(int k, string req);
    repeat (k - 1) @(posedge clk);
    #1 chk(req, "flag one edge early", idle_flag, 1'b0);
    @(posedge clk);
    #1 chk(req, "flag on threshold edge", idle_flag, 1'b1);
  endtask

  task automatic clear_flag(string req);
    @(negedge clk) idle_clr = 1'b1;
    @(negedge clk) idle_clr = 1'b0;
    chk(req, "flag after clear", idle_flag, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "flag in reset", idle_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "flag after reset", idle_flag, 1'b0);
    chk("R10", "irq after reset", idle_irq, 1'b0);
    chk("R10", "dma after reset", idle_dma_req, 1'b0);
    chk("R9", "rx_idle when not busy", rx_idle, 1'b1);
  endtask

  task automatic t_no_char();
    repeat (2000) @(negedge clk);
    chk("R3", "flag without character", idle_flag, 1'b0);
  endtask

  task automatic t_basic_and_gates();
    set_fmt(1'b1, 1'b0, 1'b0, 2'd0);
    send_char();
    expect_fire(exp_ticks(1'b1, 1'b0, 1'b0, 2'd0), "R2");
    @(negedge clk);
    chk("R7", "irq while disabled", idle_irq, 1'b0);
    chk("R8", "dma while disabled", idle_dma_req, 1'b0);
    idle_irq_en = 1'b1;
    #1 chk("R7", "irq while enabled", idle_irq, 1'b1);
    chk("R8", "dma with only irq enabled", idle_dma_req, 1'b0);
    idle_dma_en = 1'b1;
    #1 chk("R8", "dma while enabled", idle_dma_req, 1'b1);
    repeat (1000) @(negedge clk);
    chk("R5", "flag held without clear", idle_flag, 1'b1);
    clear_flag("R5");
    chk("R7", "irq after clear", idle_irq, 1'b0);
    chk("R8", "dma after clear", idle_dma_req, 1'b0);
    idle_irq_en = 1'b0; idle_dma_en = 1'b0;
    repeat (6000) @(negedge clk);
    chk("R6", "no second firing without character", idle_flag, 1'b0);
  endtask

  task automatic t_formats();
    set_fmt(1'b1, 1'b1, 1'b1, 2'd1);
    send_char();
    expect_fire(exp_ticks(1'b1, 1'b1, 1'b1, 2'd1), "R1");
    clear_flag("R5");
    set_fmt(1'b0, 1'b0, 1'b0, 2'd3);
    send_char();
    expect_fire(exp_ticks(1'b0, 1'b0, 1'b0, 2'd3), "R2");
    clear_flag("R5");
    set_fmt(1'b0, 1'b1, 1'b0, 2'd2);
    send_char();
    expect_fire(exp_ticks(1'b0, 1'b1, 1'b0, 2'd2), "R1");
    clear_flag("R5");
  endtask

  task automatic t_line_low();
    set_fmt(1'b1, 1'b0, 1'b0, 2'd0);
    send_char();
    repeat (400) @(negedge clk);
    rx_line = 1'b0;
    @(negedge clk) rx_line = 1'b1;
    expect_fire(exp_ticks(1'b1, 1'b0, 1'b0, 2'd0), "R4");
    clear_flag("R5");
  endtask

  task automatic t_busy();
    send_char();
    repeat (300) @(negedge clk);
    rx_busy = 1'b1;
    #1 chk("R9", "rx_idle while busy", rx_idle, 1'b0);
    repeat (900) @(negedge clk);
    chk("R4", "no flag while busy", idle_flag, 1'b0);
    rx_busy = 1'b0;
    expect_fire(exp_ticks(1'b1, 1'b0, 1'b0, 2'd0), "R4");
    #1 chk("R9", "rx_idle after busy", rx_idle, 1'b1);
    clear_flag("R5");
  endtask

  task automatic t_tick_gate();
    @(negedge clk) baud_tick16 = 1'b0;
    send_char();
    repeat (3000) @(negedge clk);
    chk("R4", "no flag without ticks", idle_flag, 1'b0);
    baud_tick16 = 1'b1;
    expect_fire(exp_ticks(1'b1, 1'b0, 1'b0, 2'd0), "R4");
    clear_flag("R5");
  endtask

  task automatic t_set_beats_clear();
    send_char();
    repeat (exp_ticks(1'b1, 1'b0, 1'b0, 2'd0) - 1) @(posedge clk);
    @(negedge clk) idle_clr = 1'b1;
    @(negedge clk) idle_clr = 1'b0;
    chk("R5", "set wins over same-edge clear", idle_flag, 1'b1);
    clear_flag("R5");
  endtask

  initial begin
    t_reset();
    t_no_char();
    t_basic_and_gates();
    t_formats();
    t_line_low();
    t_busy();
    t_tick_gate();
    t_set_beats_clear();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule